// File: doc/BRIEF.md
# Split-Transaction Bus Request Table

This block is the per-processor bookkeeping for a pipelined bus on which a request and its reply are separate events. The processor side hands in coherence requests, each naming a cache line and a transaction form. The table parks each one in a free slot, and the slot number becomes the bus tag that the reply will later carry. Pending slots are offered to the bus one at a time. A slot is committed, or serialized, at the moment its offer is granted without a negative acknowledge.

Replies may come back in any order. They are matched by tag alone, and the snoop result (shared, dirty) travels with the reply. Reading (GETS) and exclusive (GETX) requests wait for a reply. Write-back (PUTX) and upgrade slots are released as soon as they win the bus.

A grant that is refused with a NACK leaves the slot allocated. The slot then sits out a fixed back-off before it is offered again. Only one slot may hold a given line at a time. A new request is accepted only when a slot is free, which reserves the room for its reply before it ever reaches the bus.

Top module: `rt_split_table`

## Requirements
- R1: After reset every slot is free: `req_ready` is 1, `bus_valid` is 0 and `done_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only if a slot is free and no slot holds the same line. `req_tag` is the lowest free slot index, and that index becomes the request's bus tag. With all 8 slots in use, `req_ready` is 0.
- R3: While any slot holds a line, in any state (pending, backing off or waiting for a reply), a new request for that line sees `req_ready` at 0.
- R4: `bus_valid` is 1 whenever some slot is pending. `bus_tag`, `bus_kind` and `bus_line` then describe the lowest-index pending slot.
- R5: The transaction forms are encoded GETS=0, GETX=1, PUTX=2, Upgrade=3. A GETS or GETX slot that is granted (`bus_valid`, `bus_ready`, no `bus_nack`) stops requesting the bus and waits for its reply.
- R6: A reply (`rsp_valid`) whose `rsp_tag` names a waiting slot frees that slot. One cycle later `done_valid` pulses for one cycle, carrying that tag, the slot's kind and line, and the `rsp_shared`/`rsp_dirty` bits. Replies may arrive in any order.
- R7: A PUTX or Upgrade slot is freed on the edge of its granted, un-NACKed win. It produces no `done_valid`.
- R8: A granted offer with `bus_nack` at 1 keeps the slot and its line. The slot withholds the bus request for exactly 4 cycles (parameter BACKOFF) and then offers again.
- R9: A reply whose tag names a slot that is free, pending or backing off is ignored. No `done_valid` follows, and the slot's state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Table can take the offered request |
| req_kind | input | 2 | Transaction form (R5 encoding) |
| req_line | input | 16 | Cache line address |
| req_tag | output | 3 | Slot/tag that an accepted request receives |
| bus_valid | output | 1 | A slot is offering a request to the bus |
| bus_ready | input | 1 | Bus grant for the offered request |
| bus_nack | input | 1 | Granted request refused; meaningful only with bus_ready |
| bus_kind | output | 2 | Form of the offered request |
| bus_line | output | 16 | Line of the offered request |
| bus_tag | output | 3 | Tag of the offered request |
| rsp_valid | input | 1 | Data reply present (always sunk) |
| rsp_tag | input | 3 | Tag carried by the reply |
| rsp_shared | input | 1 | Snoop result: another cache keeps a copy |
| rsp_dirty | input | 1 | Snoop result: a cache supplied dirty data |
| done_valid | output | 1 | Completion pulse for a matched reply |
| done_tag | output | 3 | Tag of the completed slot |
| done_kind | output | 2 | Form of the completed transaction |
| done_line | output | 16 | Line of the completed transaction |
| done_shared | output | 1 | Snoop shared bit of the reply |
| done_dirty | output | 1 | Snoop dirty bit of the reply |

## Verification
The assertions assume that `bus_nack` only matters together with `bus_ready`. They also assume that the processor side follows valid/ready: a request is considered taken only on an edge where both are high, and nothing pushes back on replies or completions. The stimulus holds `bus_nack` low except in the single grant cycle that is meant to be refused. It changes inputs only at the falling edge. It sends replies both to waiting slots and, on purpose, to free and pending slots, so that the ignore rule is exercised.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    K_GETS = 2'd0,
    K_GETX = 2'd1,
    K_PUTX = 2'd2,
    K_UPGR = 2'd3
  } rt_kind_e;

  typedef enum logic [1:0] {
    S_FREE = 2'd0,
    S_PEND = 2'd1,
    S_BACK = 2'd2,
    S_WAIT = 2'd3
  } rt_state_e;

  function automatic logic kind_needs_reply(rt_kind_e k);
    return (k == K_GETS) || (k == K_GETX);
  endfunction
endpackage

// File: rtl/rt_lowest.sv
module rt_lowest #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/rt_entry.sv
module rt_entry
  import rt_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int BACKOFF = 4,
  localparam int CNT_W  = $clog2(BACKOFF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  rt_kind_e          kind_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              win_i,
  input  logic              nack_i,
  input  logic              rsp_i,
  output logic              valid_o,
  output logic              pend_o,
  output logic              wait_o,
  output rt_kind_e          kind_o,
  output logic [LINE_W-1:0] line_o
);
  rt_state_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  rt_kind_e           kind_q;
  logic [LINE_W-1:0]  line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_FREE;
      cnt_q  <= '0;
      kind_q <= K_GETS;
      line_q <= '0;
    end else begin
      case (st_q)
        S_FREE: if (alloc_i) begin
          st_q   <= S_PEND;
          kind_q <= kind_i;
          line_q <= line_i;
        end
        S_PEND: if (win_i) begin
          if (nack_i) begin
            st_q  <= S_BACK;
            cnt_q <= CNT_W'(BACKOFF);
          end else if (kind_needs_reply(kind_q)) begin
            st_q <= S_WAIT;
          end else begin
            st_q <= S_FREE;
          end
        end
        S_BACK: begin
          if (cnt_q <= CNT_W'(1)) st_q <= S_PEND;
          else cnt_q <= cnt_q - CNT_W'(1);
        end
        S_WAIT: if (rsp_i) st_q <= S_FREE;
        default: st_q <= S_FREE;
      endcase
    end
  end

  assign valid_o = (st_q != S_FREE);
  assign pend_o  = (st_q == S_PEND);
  assign wait_o  = (st_q == S_WAIT);
  assign kind_o  = kind_q;
  assign line_o  = line_q;

  // R8: a refused win keeps the slot allocated and silent on the bus
  a_r8_nack_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && win_i && nack_i) |=> (valid_o && !pend_o && $stable(line_o)));

  // R7: write-back and upgrade release on their winning edge
  a_r7_release_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && win_i && !nack_i && !kind_needs_reply(kind_o)) |=> !valid_o);
endmodule

// File: rtl/rt_split_table.sv
module rt_split_table
  import rt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int LINE_W  = 16,
  parameter int BACKOFF = 4,
  localparam int TAG_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [LINE_W-1:0] req_line,
  output logic [TAG_W-1:0]  req_tag,
  output logic              bus_valid,
  input  logic              bus_ready,
  input  logic              bus_nack,
  output logic [1:0]        bus_kind,
  output logic [LINE_W-1:0] bus_line,
  output logic [TAG_W-1:0]  bus_tag,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic              rsp_shared,
  input  logic              rsp_dirty,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic [1:0]        done_kind,
  output logic [LINE_W-1:0] done_line,
  output logic              done_shared,
  output logic              done_dirty
);
  logic [ENTRIES-1:0] valid_v, pend_v, wait_v, clash_v;
  rt_kind_e           kind_v [ENTRIES];
  logic [LINE_W-1:0]  line_v [ENTRIES];
  logic               free_found, take, win, rsp_hit;
  logic [TAG_W-1:0]   free_idx;

  rt_lowest #(.N(ENTRIES)) u_free (
    .vec_i(~valid_v), .found_o(free_found), .idx_o(free_idx));

  rt_lowest #(.N(ENTRIES)) u_issue (
    .vec_i(pend_v), .found_o(bus_valid), .idx_o(bus_tag));

  assign req_ready = free_found && !(|clash_v);
  assign req_tag   = free_idx;
  assign take      = req_valid && req_ready;
  assign win       = bus_valid && bus_ready;
  assign bus_kind  = kind_v[bus_tag];
  assign bus_line  = line_v[bus_tag];
  assign rsp_hit   = rsp_valid && wait_v[rsp_tag];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    rt_entry #(.LINE_W(LINE_W), .BACKOFF(BACKOFF)) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc_i(take && (free_idx == TAG_W'(i))),
      .kind_i (rt_kind_e'(req_kind)),
      .line_i (req_line),
      .win_i  (win && (bus_tag == TAG_W'(i))),
      .nack_i (bus_nack),
      .rsp_i  (rsp_valid && (rsp_tag == TAG_W'(i))),
      .valid_o(valid_v[i]),
      .pend_o (pend_v[i]),
      .wait_o (wait_v[i]),
      .kind_o (kind_v[i]),
      .line_o (line_v[i])
    );
    assign clash_v[i] = valid_v[i] && (line_v[i] == req_line);

    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_pair
      // R3: two live slots never share a line
      a_r3_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_v[i] && valid_v[j] && (line_v[i] == line_v[j])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid  <= 1'b0;
      done_tag    <= '0;
      done_kind   <= 2'd0;
      done_line   <= '0;
      done_shared <= 1'b0;
      done_dirty  <= 1'b0;
    end else begin
      done_valid <= rsp_hit;
      if (rsp_hit) begin
        done_tag    <= rsp_tag;
        done_kind   <= kind_v[rsp_tag];
        done_line   <= line_v[rsp_tag];
        done_shared <= rsp_shared;
        done_dirty  <= rsp_dirty;
      end
    end
  end

  // R2: an accepted request lands as pending in the slot it was told
  a_r2_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> pend_v[$past(req_tag)]);

  // R4: the offered tag is always a pending slot
  a_r4_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> pend_v[bus_tag]);

  // R6: a matched reply completes with its own tag next cycle
  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && wait_v[rsp_tag]) |=> (done_valid && done_tag == $past(rsp_tag)));

  // R9: an unmatched reply produces nothing
  a_r9_stray_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !wait_v[rsp_tag]) |=> !done_valid);
endmodule

// File: tb/tb_rt_split_table.sv
module tb_rt_split_table;
  localparam int LW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, bus_ready = 0, bus_nack = 0, rsp_valid = 0;
  logic rsp_shared = 0, rsp_dirty = 0;
  logic [1:0] req_kind = 0;
  logic [LW-1:0] req_line = 0;
  logic [2:0] rsp_tag = 0;
  logic req_ready, bus_valid, done_valid, done_shared, done_dirty;
  logic [2:0] req_tag, bus_tag, done_tag;
  logic [1:0] bus_kind, done_kind;
  logic [LW-1:0] bus_line, done_line;
  int ncmp = 0, nbad = 0;

  always #2.5 clk = ~clk;

  rt_split_table dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_line(req_line), .req_tag(req_tag),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_nack(bus_nack),
    .bus_kind(bus_kind), .bus_line(bus_line), .bus_tag(bus_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_shared(rsp_shared),
    .rsp_dirty(rsp_dirty), .done_valid(done_valid), .done_tag(done_tag),
    .done_kind(done_kind), .done_line(done_line), .done_shared(done_shared),
    .done_dirty(done_dirty));

  task automatic chk(input string rq, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic alloc(input int kind, input int line, input int exp_tag);
    req_valid = 1; req_kind = 2'(kind); req_line = LW'(line);
    #1;
    chk("R2 ready", int'(req_ready), 1);
    chk("R2 tag", int'(req_tag), exp_tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++; ncmp++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 bus_valid", int'(bus_valid), 0);
    chk("R1 done", int'(done_valid), 0);

    // R2 fill all slots: tags ascend, kinds GETS/GETX alternate
    for (int i = 0; i < 8; i++) alloc(i % 2, 16 + i, i);
    req_line = LW'(100);
    #1 chk("R2 full", int'(req_ready), 0);

    // R4/R5 issue order is lowest pending index
    for (int i = 0; i < 8; i++) begin
      bus_ready = 1;
      #1;
      chk("R4 valid", int'(bus_valid), 1);
      chk("R4 tag", int'(bus_tag), i);
      chk("R4 line", int'(bus_line), 16 + i);
      chk("R4 kind", int'(bus_kind), i % 2);
      @(negedge clk);
    end
    bus_ready = 0;
    #1 chk("R5 waiting", int'(bus_valid), 0);

    // R6 replies in reverse order
    for (int i = 7; i >= 0; i--) begin
      rsp_valid = 1; rsp_tag = 3'(i);
      rsp_shared = i[0]; rsp_dirty = i[1];
      @(negedge clk);
      rsp_valid = 0;
      #1;
      chk("R6 done", int'(done_valid), 1);
      chk("R6 tag", int'(done_tag), i);
      chk("R6 line", int'(done_line), 16 + i);
      chk("R6 kind", int'(done_kind), i % 2);
      chk("R6 shared", int'(done_shared), i % 2);
      chk("R6 dirty", int'(done_dirty), (i / 2) % 2);
      chk("R2 lowest free", int'(req_tag), i);
    end

    // R9 reply to a free slot
    rsp_valid = 1; rsp_tag = 3'd3;
    @(negedge clk);
    rsp_valid = 0;
    #1 chk("R9 free slot", int'(done_valid), 0);

    // R3 same-line refusal
    alloc(0, 5, 0);
    req_line = LW'(5);
    #1 chk("R3 clash", int'(req_ready), 0);
    req_line = LW'(6);
    #1 chk("R3 other line", int'(req_ready), 1);

    // R9 reply to a pending slot is ignored
    alloc(2, 9, 1);
    rsp_valid = 1; rsp_tag = 3'd0;
    @(negedge clk);
    rsp_valid = 0;
    #1;
    chk("R9 pending", int'(done_valid), 0);
    chk("R9 still pending", int'(bus_tag), 0);
    chk("R9 still offered", int'(bus_valid), 1);

    // R7 PUTX freed at win
    bus_ready = 1;
    @(negedge clk);
    #1;
    chk("R4 next tag", int'(bus_tag), 1);
    chk("R5 putx kind", int'(bus_kind), 2);
    chk("R4 putx line", int'(bus_line), 9);
    @(negedge clk);
    bus_ready = 0;
    req_line = LW'(9);
    #1;
    chk("R7 bus idle", int'(bus_valid), 0);
    chk("R7 line free", int'(req_ready), 1);
    chk("R7 slot free", int'(req_tag), 1);
    chk("R7 no done", int'(done_valid), 0);

    // R8 NACK back-off on an upgrade
    alloc(3, 12, 1);
    bus_ready = 1; bus_nack = 1;
    #1 chk("R8 offered", int'(bus_tag), 1);
    @(negedge clk);
    bus_ready = 0; bus_nack = 0;
    req_line = LW'(12);
    for (int k = 1; k <= 4; k++) begin
      #1;
      chk("R8 quiet", int'(bus_valid), 0);
      chk("R8 line held", int'(req_ready), 0);
      @(negedge clk);
    end
    #1;
    chk("R8 retry", int'(bus_valid), 1);
    chk("R8 retry tag", int'(bus_tag), 1);
    chk("R8 retry kind", int'(bus_kind), 3);
    bus_ready = 1;
    @(negedge clk);
    bus_ready = 0;
    #1;
    chk("R7 upgrade gone", int'(bus_valid), 0);
    chk("R7 upgrade line free", int'(req_ready), 1);

    // R6 finish the GETS with both snoop bits
    rsp_valid = 1; rsp_tag = 3'd0; rsp_shared = 1; rsp_dirty = 1;
    @(negedge clk);
    rsp_valid = 0;
    #1;
    chk("R6 final done", int'(done_valid), 1);
    chk("R6 final line", int'(done_line), 5);
    chk("R6 final snoop", int'({done_shared, done_dirty}), 3);
    @(negedge clk);
    #1 chk("R6 one pulse", int'(done_valid), 0);
    summary();
  end
endmodule